// File: doc/BRIEF.md
# Adaptive Erase Loop Sequencer

This block drives an incremental-step erase of one flash block from the controller side. A start command launches a short probing pulse at the lowest voltage step. A verify step then senses the block and returns a fail-bit count: the number of bitlines that still hold at least one cell that is not erased far enough. That count selects the length of the next pulse. The selection goes through programmable ascending thresholds and a table of durations, so a block that is nearly erased gets a short pulse and a resistant block gets a long one. Each retry raises the voltage step by one.

Pulse lengths are counted in ticks of a programmable prescaler. Every pulse is capped at a worst-case length. An optional ECC-margin mode accepts a small residual fail-bit count as a pass and shortens every selected pulse by one table bin. The sequencer stops on a passing verify or at a programmable loop limit. It then reports pass/fail, the number of pulses issued and the total pulse time in ticks.

The verify step uses a request/acknowledge handshake, so the sensing delay of the array may vary from loop to loop.

Top module: `adapt_erase_seq`

## Requirements
- R1: After an accepted start, the first pulse uses the probe duration `probe_dur_i` (after the R4 clamp) at voltage step 0, with `arr_addr_o` equal to the block address captured at start.
- R2: `pulse_en_o` stays high for exactly `pulse_dur_o * (prescale_i + 1)` consecutive clock cycles per pulse.
- R3: After a failed verify, the next duration comes from bin i, the lowest index whose threshold (`thr_i[i*FBC_W +: FBC_W]`, ascending) is greater than or equal to the fail-bit count. Bin N is used when the count exceeds every threshold. Bin k's duration is `dur_tab_i[k*DUR_W +: DUR_W]`.
- R4: Every pulse duration is clamped to the range 1 to `max_dur_i`, and a zero `max_dur_i` is treated as 1.
- R5: Each retry pulse uses a voltage step one higher than the pulse before it.
- R6: `vfy_req_o` rises when a pulse ends and stays high until a cycle with `vfy_ack_i` high. `fbc_i` is sampled only in that cycle, and no pulse is issued while the request is pending.
- R7: A fail-bit count of 0 is a pass. When `ecc_en_i` is high, a count below `ecc_tol_i` is also a pass.
- R8: When `ecc_en_i` is high, the bin chosen by R3 is lowered by one, and bin 0 stays at 0.
- R9: If a verify fails after `max_loops_i` pulses (0 treated as 1), the sequence ends with the pass flag low and the loop count equal to that limit.
- R10: `busy_o` is high from the cycle after an accepted start until the sequence ends. A start during busy has no effect on the address, the loops or the result.
- R11: `done_o` is high for exactly one cycle, in the same cycle that `busy_o` falls. `pass_o`, `loops_o` and `erase_time_o` then hold until the next accepted start.
- R12: `loops_o` counts the pulses issued, and `erase_time_o` equals the sum of the pulse durations in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an erase sequence |
| blk_addr_i | input | ADDR_W | Block address captured at start |
| prescale_i | input | PRE_W | Clocks per duration tick, minus one |
| probe_dur_i | input | DUR_W | Duration of the first (probe) pulse in ticks |
| max_dur_i | input | DUR_W | Worst-case cap on any pulse, in ticks |
| max_loops_i | input | LOOP_W | Pulse limit before the sequence fails |
| ecc_en_i | input | 1 | Enable the ECC-margin acceptance and bin shortening |
| ecc_tol_i | input | FBC_W | Fail-bit count tolerance in ECC-margin mode |
| thr_i | input | N*FBC_W | Ascending fail-bit thresholds, entry 0 lowest |
| dur_tab_i | input | (N+1)*DUR_W | Duration per bin in ticks |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pass_o | output | 1 | Last sequence passed verify |
| loops_o | output | LOOP_W | Pulses issued in the last sequence |
| erase_time_o | output | TIME_W | Total pulse ticks in the last sequence |
| arr_addr_o | output | ADDR_W | Block address to the array |
| pulse_en_o | output | 1 | Erase pulse enable |
| vstep_o | output | VSTEP_W | Erase voltage step index |
| pulse_dur_o | output | DUR_W | Duration of the current pulse in ticks |
| vfy_req_o | output | 1 | Verify request |
| vfy_ack_i | input | 1 | Verify acknowledge with valid count |
| fbc_i | input | FBC_W | Fail-bit count from verify |

## Verification
A wrong bin choice or clamp shows up within one loop: the next `pulse_en_o` window has the wrong length in cycles. A prescaler or tick counter that is off by one shows on the very first probe pulse. A voltage step or loop counter that is stuck or skipped shows at the next pulse rise, or in `loops_o` in the `done_o` cycle. A wrong pass decision ends the sequence one verify too early or too late, which changes `loops_o` and `erase_time_o`. The bench sweeps fail-bit counts on both sides of every threshold and the ECC tolerance, with ECC-margin mode off and on. It times every pulse window against values computed from the tables.

// File: rtl/adapt_erase_pkg.sv
package adapt_erase_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_VERIFY = 2'd2
  } seq_st_e;
endpackage

// File: rtl/aes_bin_sel.sv
module aes_bin_sel #(
  parameter int N     = 3,
  parameter int FBC_W = 16,
  localparam int BIN_W = $clog2(N + 1)
) (
  input  logic [FBC_W-1:0]   fbc_i,
  input  logic [N*FBC_W-1:0] thr_i,
  output logic [BIN_W-1:0]   bin_o
);
  logic [N-1:0] le;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign le[g] = (fbc_i <= thr_i[g*FBC_W +: FBC_W]);
  end

  // lowest threshold not exceeded wins
  always_comb begin
    bin_o = BIN_W'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (le[i]) bin_o = BIN_W'(i);
    end
  end
endmodule

// File: rtl/aes_dur_sel.sv
module aes_dur_sel #(
  parameter int N     = 3,
  parameter int FBC_W = 16,
  parameter int DUR_W = 8
) (
  input  logic                   probe_sel_i,
  input  logic [DUR_W-1:0]       probe_dur_i,
  input  logic [DUR_W-1:0]       max_dur_i,
  input  logic                   ecc_en_i,
  input  logic [FBC_W-1:0]       fbc_i,
  input  logic [N*FBC_W-1:0]     thr_i,
  input  logic [(N+1)*DUR_W-1:0] dur_tab_i,
  output logic [DUR_W-1:0]       dur_o
);
  localparam int BIN_W = $clog2(N + 1);

  logic [BIN_W-1:0] bin, bin_adj;
  logic [DUR_W-1:0] raw, cap;

  aes_bin_sel #(.N(N), .FBC_W(FBC_W)) u_bin (
    .fbc_i (fbc_i),
    .thr_i (thr_i),
    .bin_o (bin)
  );

  assign bin_adj = (ecc_en_i && bin != '0) ? bin - BIN_W'(1) : bin;
  assign raw     = probe_sel_i ? probe_dur_i : dur_tab_i[32'(bin_adj)*DUR_W +: DUR_W];
  assign cap     = (max_dur_i == '0) ? DUR_W'(1) : max_dur_i;

  always_comb begin
    if (raw == '0)      dur_o = DUR_W'(1);
    else if (raw > cap) dur_o = cap;
    else                dur_o = raw;
  end
endmodule

// File: rtl/aes_pulse_timer.sv
module aes_pulse_timer #(
  parameter int PRE_W = 4,
  parameter int DUR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             tick_o,
  output logic             last_o
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DUR_W-1:0] tick_cnt;

  assign tick_o = run_i && (pre_cnt == prescale_i);
  assign last_o = tick_o && (tick_cnt == dur_i - DUR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (clr_i) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (run_i) begin
      if (tick_o) begin
        pre_cnt  <= '0;
        tick_cnt <= last_o ? '0 : tick_cnt + DUR_W'(1);
      end else begin
        pre_cnt  <= pre_cnt + PRE_W'(1);
      end
    end
  end

  AST_TICK_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && dur_i != '0 |-> tick_cnt < dur_i); // R2
  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> pre_cnt <= prescale_i); // R2
endmodule

// File: rtl/adapt_erase_seq.sv
module adapt_erase_seq
  import adapt_erase_pkg::*;
#(
  parameter int N       = 3,
  parameter int FBC_W   = 16,
  parameter int DUR_W   = 8,
  parameter int PRE_W   = 4,
  parameter int LOOP_W  = 4,
  parameter int VSTEP_W = 4,
  parameter int ADDR_W  = 8,
  parameter int TIME_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [ADDR_W-1:0]      blk_addr_i,
  input  logic [PRE_W-1:0]       prescale_i,
  input  logic [DUR_W-1:0]       probe_dur_i,
  input  logic [DUR_W-1:0]       max_dur_i,
  input  logic [LOOP_W-1:0]      max_loops_i,
  input  logic                   ecc_en_i,
  input  logic [FBC_W-1:0]       ecc_tol_i,
  input  logic [N*FBC_W-1:0]     thr_i,
  input  logic [(N+1)*DUR_W-1:0] dur_tab_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   pass_o,
  output logic [LOOP_W-1:0]      loops_o,
  output logic [TIME_W-1:0]      erase_time_o,
  output logic [ADDR_W-1:0]      arr_addr_o,
  output logic                   pulse_en_o,
  output logic [VSTEP_W-1:0]     vstep_o,
  output logic [DUR_W-1:0]       pulse_dur_o,
  output logic                   vfy_req_o,
  input  logic                   vfy_ack_i,
  input  logic [FBC_W-1:0]       fbc_i
);
  seq_st_e          st;
  logic [DUR_W-1:0] cur_dur, sel_dur;
  logic [LOOP_W-1:0] max_eff;
  logic             tick, last, vfy_ok;

  assign busy_o      = (st != ST_IDLE);
  assign pulse_en_o  = (st == ST_PULSE);
  assign vfy_req_o   = (st == ST_VERIFY);
  assign pulse_dur_o = cur_dur;
  assign max_eff     = (max_loops_i == '0) ? LOOP_W'(1) : max_loops_i;
  assign vfy_ok      = (fbc_i == '0) || (ecc_en_i && fbc_i < ecc_tol_i);

  aes_dur_sel #(.N(N), .FBC_W(FBC_W), .DUR_W(DUR_W)) u_dur_sel (
    .probe_sel_i (st == ST_IDLE),
    .probe_dur_i (probe_dur_i),
    .max_dur_i   (max_dur_i),
    .ecc_en_i    (ecc_en_i),
    .fbc_i       (fbc_i),
    .thr_i       (thr_i),
    .dur_tab_i   (dur_tab_i),
    .dur_o       (sel_dur)
  );

  aes_pulse_timer #(.PRE_W(PRE_W), .DUR_W(DUR_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (pulse_en_o),
    .clr_i      (st == ST_IDLE),
    .prescale_i (prescale_i),
    .dur_i      (cur_dur),
    .tick_o     (tick),
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st           <= ST_IDLE;
      cur_dur      <= DUR_W'(1);
      done_o       <= 1'b0;
      pass_o       <= 1'b0;
      loops_o      <= '0;
      erase_time_o <= '0;
      arr_addr_o   <= '0;
      vstep_o      <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          arr_addr_o   <= blk_addr_i;
          cur_dur      <= sel_dur;
          pass_o       <= 1'b0;
          loops_o      <= '0;
          erase_time_o <= '0;
          vstep_o      <= '0;
          st           <= ST_PULSE;
        end
        ST_PULSE: begin
          if (tick) erase_time_o <= erase_time_o + TIME_W'(1);
          if (last) begin
            loops_o <= loops_o + LOOP_W'(1);
            st      <= ST_VERIFY;
          end
        end
        ST_VERIFY: if (vfy_ack_i) begin
          if (vfy_ok) begin
            pass_o <= 1'b1;
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else if (loops_o >= max_eff) begin
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            cur_dur <= sel_dur;
            if (vstep_o != '1) vstep_o <= vstep_o + VSTEP_W'(1);
            st      <= ST_PULSE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_FIRST_STEP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> vstep_o == '0 && loops_o == '0); // R1
  AST_DUR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_en_o |-> pulse_dur_o != '0); // R4
  AST_DUR_CAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_en_o && max_dur_i != '0 |-> pulse_dur_o <= max_dur_i); // R4
  AST_VSTEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_en_o) && loops_o != '0 && $past(vstep_o) != '1
      |-> vstep_o == $past(vstep_o) + VSTEP_W'(1)); // R5
  AST_VFY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_req_o && !vfy_ack_i |=> vfy_req_o && !pulse_en_o); // R6
  AST_ECC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_req_o && vfy_ack_i && ecc_en_i && fbc_i != '0 && fbc_i < ecc_tol_i
      |=> done_o && pass_o); // R7
  AST_FAIL_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !pass_o |-> loops_o == max_eff); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(arr_addr_o)); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_WITH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R11
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(loops_o) && $stable(erase_time_o) && $stable(pass_o)); // R11
endmodule

// File: tb/adapt_erase_seq_tb.sv
module adapt_erase_seq_tb;
  localparam int N = 3, FBC_W = 16, DUR_W = 8, PRE_W = 4, LOOP_W = 4;
  localparam int VSTEP_W = 4, ADDR_W = 8, TIME_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                   start_i = 0, ecc_en = 0, ack = 0;
  logic [ADDR_W-1:0]      blk = '0;
  logic [PRE_W-1:0]       prescale = '0;
  logic [DUR_W-1:0]       probe = 8'd1, maxd = 8'd7;
  logic [LOOP_W-1:0]      maxl = 4'd6;
  logic [FBC_W-1:0]       tol = 16'd4, fbc = '0;
  logic [N*FBC_W-1:0]     thr;
  logic [(N+1)*DUR_W-1:0] dtab;
  logic busy, done, pass, pen, vreq;
  logic [LOOP_W-1:0]  loops;
  logic [TIME_W-1:0]  etime;
  logic [ADDR_W-1:0]  aaddr;
  logic [VSTEP_W-1:0] vstep;
  logic [DUR_W-1:0]   pdur;

  int thr_v[N]   = '{10, 20, 40};
  int dur_v[N+1] = '{2, 3, 5, 9};
  int seq[8];
  int n_chk = 0, n_err = 0;

  always_comb begin
    for (int i = 0; i < N; i++) thr[i*FBC_W +: FBC_W] = FBC_W'(thr_v[i]);
    for (int i = 0; i <= N; i++) dtab[i*DUR_W +: DUR_W] = DUR_W'(dur_v[i]);
  end

  adapt_erase_seq #(.N(N), .FBC_W(FBC_W), .DUR_W(DUR_W), .PRE_W(PRE_W), .LOOP_W(LOOP_W),
    .VSTEP_W(VSTEP_W), .ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .blk_addr_i(blk),
    .prescale_i(prescale), .probe_dur_i(probe), .max_dur_i(maxd), .max_loops_i(maxl),
    .ecc_en_i(ecc_en), .ecc_tol_i(tol), .thr_i(thr), .dur_tab_i(dtab),
    .busy_o(busy), .done_o(done), .pass_o(pass), .loops_o(loops), .erase_time_o(etime),
    .arr_addr_o(aaddr), .pulse_en_o(pen), .vstep_o(vstep), .pulse_dur_o(pdur),
    .vfy_req_o(vreq), .vfy_ack_i(ack), .fbc_i(fbc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampd(input int d);
    int c = (maxd == 0) ? 1 : int'(maxd);
    if (d == 0) return 1;
    if (d > c) return c;
    return d;
  endfunction

  function automatic int ref_dur(input int f);
    int b = N;
    for (int i = N - 1; i >= 0; i--) if (f <= thr_v[i]) b = i;
    if (ecc_en && b > 0) b--;
    return clampd(dur_v[b]);
  endfunction

  function automatic bit ref_pass(input int f);
    return (f == 0) || (ecc_en && f < int'(tol));
  endfunction

  // Runs one sequence; the array model answers verify li with seq[li].
  task automatic run(input bit poke_busy);
    int li = 0, cnt = 0, guard = 0, exp_d, exp_loops, exp_time, lim;
    bit exp_pass = 0;
    logic [ADDR_W-1:0] a0;
    lim = (maxl == 0) ? 1 : int'(maxl);
    exp_time = 0;
    exp_loops = 0;
    for (int i = 0; i < lim; i++) begin
      exp_d = (i == 0) ? clampd(int'(probe)) : ref_dur(seq[i-1]);
      exp_time += exp_d;
      exp_loops = i + 1;
      if (ref_pass(seq[i])) begin exp_pass = 1; break; end
    end
    a0 = blk;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    chk(vstep == '0 && aaddr == a0, "R1 first pulse step/addr", int'(vstep), 0);
    while (guard < 5000) begin
      guard++;
      if (done) break;
      if (pen) cnt++;
      else if (vreq) begin
        exp_d = (li == 0) ? clampd(int'(probe)) : ref_dur(seq[li-1]);
        chk(cnt == exp_d * (int'(prescale) + 1),
            li == 0 ? "R1 R2 probe pulse length" : "R2 R3 R4 R8 pulse length",
            cnt, exp_d * (int'(prescale) + 1));
        chk(int'(vstep) == li, "R5 voltage step", int'(vstep), li);
        repeat (li % 3) begin
          @(negedge clk);
          chk(vreq && !pen, "R6 request held", int'(vreq), 1);
        end
        if (poke_busy && li == 0) begin
          start_i = 1; blk = ~a0;
          @(negedge clk) start_i = 0;
        end
        ack = 1; fbc = FBC_W'(seq[li]);
        @(negedge clk) ack = 0; fbc = 16'hFFFF;
        li++; cnt = 0;
        continue;
      end
      @(negedge clk);
    end
    chk(done == 1'b1 && busy == 1'b0, "R11 done with busy low", int'(done), 1);
    chk(pass == exp_pass, exp_pass ? "R7 pass" : "R9 fail at limit", int'(pass), int'(exp_pass));
    chk(int'(loops) == exp_loops, "R9 R12 loops", int'(loops), exp_loops);
    chk(int'(etime) == exp_time, "R12 erase time", int'(etime), exp_time);
    chk(aaddr == a0, "R10 address kept", int'(aaddr), int'(a0));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", int'(done), 0);
    chk(int'(loops) == exp_loops && int'(etime) == exp_time && pass == exp_pass,
        "R11 results held", int'(etime), exp_time);
    blk = a0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int fl[12] = '{1, 3, 4, 5, 10, 11, 20, 21, 40, 41, 200, 9};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pen && !vreq && loops == 0 && etime == 0, "R11 reset state",
        int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    blk = 8'h5A;
    // bin sweep across thresholds and tolerance, ECC margin off/on, two prescales
    for (int p = 0; p < 3; p += 2) begin
      prescale = PRE_W'(p);
      for (int e = 0; e < 2; e++) begin
        ecc_en = e[0];
        for (int k = 0; k < 12; k++) begin
          foreach (seq[i]) seq[i] = 0;
          seq[0] = fl[k];
          run(k == 4);
        end
      end
    end
    // multi-loop descent with rising steps
    prescale = 1; ecc_en = 0;
    seq = '{50, 25, 12, 6, 0, 0, 0, 0};
    run(0);
    // loop limit reached
    foreach (seq[i]) seq[i] = 30;
    maxl = 3; run(1);
    maxl = 0; run(0);
    // probe of zero and cap of zero clamp to one tick
    maxl = 6; probe = 0; seq = '{200, 0, 0, 0, 0, 0, 0, 0};
    run(0);
    maxd = 0; probe = 5; run(0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule